// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers sixteen interrupt sources into a single active-low request line for a processor with vectored interrupts. The sixteen sources are split into two banks of eight. Each source has an enable bit, a pending bit and a mask bit. A one-cycle event pulse sets the pending bit of an enabled source. The request line is asserted while any source is both pending and unmasked. A small register port, addressed by five select bits, gives read and write access to the enables, the pending bits, the masks and a vector base.

The block also sits in a priority daisy chain. An active-low chain input says that no upstream device is requesting. The active-low chain output passes permission downstream only when that input is asserted and this block has no request of its own. During an acknowledge cycle the block answers only when it holds chain permission. It then drives an 8-bit vector onto the low byte of the data bus. The vector is made from a programmable upper nibble and the number of the winning channel, and the winner's pending bit is cleared.

An acknowledge state machine has three states:
- `ST_IDLE`: no acknowledge is in progress.
- `ST_RESP`: this block is driving the vector.
- `ST_PASS`: an acknowledge is in progress but belongs to another device.

It has these transitions:
- `IDLE->RESP`: a legal acknowledge arrives with chain permission and a request present.
- `IDLE->PASS`: a legal acknowledge arrives without permission or without a request.
- `IDLE->IDLE`: there is no acknowledge, or acknowledge and chip select are asserted together.
- `RESP->RESP` and `PASS->PASS`: the acknowledge is still held.
- `RESP->IDLE` and `PASS->IDLE`: the acknowledge is released.

Top module: `vector_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and mask register and the vector base read as 0, `irq_n` is 1 and `vec_oe` is 0.
- R2: An `evt_i[k]` pulse sets pending bit k only when enable bit k is 1. A pulse on a channel that is already pending leaves it pending.
- R3: `irq_n` is 0 exactly when some channel is both pending and unmasked, so clearing either the mask or the pending bit negates it.
- R4: Writing a pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: Among pending, unmasked channels, the highest-numbered one wins (channel 15 highest, channel 0 lowest).
- R6: Register select values are: enable 0x00 (ch 7:0) and 0x01 (ch 15:8), pending 0x02/0x03, mask 0x04/0x05, and vector base 0x06. The vector base register keeps bits 7:4 only, and bits 3:0 read as 0.
- R7: The cycle after a legal acknowledge is accepted, `vec_oe` is 1 and `vec_data` equals {base[7:4], winner[3:0]}. The winner's pending bit is cleared, and `irq_n` stays 0 if other unmasked channels remain pending.
- R8: When `iei_n` is 1 or no request is present, an acknowledge leaves `vec_oe` 0, keeps `vec_data` at 0 and clears no pending bit.
- R9: `ieo_n` is 0 only when `iei_n` is 0 and `irq_n` is 1.
- R10: When `cs_n` and `iack_n` are both 0, register writes are ignored and no acknowledge is started.
- R11: While `iack_n` stays 0, `vec_data` holds the accepted vector, even when new events arrive. One clock after `iack_n` returns to 1, `vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Register chip select, active low |
| we | input | 1 | Write strobe (1 = write, 0 = read) |
| rsel | input | 5 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| evt_i | input | 16 | One-cycle event pulses, one per channel |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| iei_n | input | 1 | Daisy-chain enable in, active low |
| ieo_n | output | 1 | Daisy-chain enable out, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector bus drive enable |
| vec_data | output | 8 | Vector byte during acknowledge, else 0 |

## Verification
The hardest situation to reach is an event that arrives while the vector is already being driven. That event raises a higher-priority request in the middle of an acknowledge. The bench holds `iack_n` low for several cycles, pulses channel 15 during the hold, and checks that the driven vector does not move while the request stays asserted. A second hard case is the illegal overlap of chip select and acknowledge. The bench drives a mask write together with an acknowledge, releases both in the same cycle, and then reads the mask back to show that it did not change.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_PASS = 2'd2
    } ack_state_t;

    localparam int KIND_ENA   = 0;
    localparam int KIND_PEND  = 1;
    localparam int KIND_MASK  = 2;
    localparam int KIND_VBASE = 3;

endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
    parameter int BANK_W = 8,
    parameter int AW     = 5,
    parameter int NBANK  = 2,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     rsel,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] evt,
    input  logic [BANK_W-1:0] ack_clr,
    output logic [BANK_W-1:0] ena_q,
    output logic [BANK_W-1:0] pend_q,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] rd_val
);
    import vic_pkg::*;

    localparam logic [AW-1:0] A_ENA  = AW'(KIND_ENA  * NBANK + IDX);
    localparam logic [AW-1:0] A_PEND = AW'(KIND_PEND * NBANK + IDX);
    localparam logic [AW-1:0] A_MASK = AW'(KIND_MASK * NBANK + IDX);

    logic [BANK_W-1:0] sw_clr;
    logic [BANK_W-1:0] pend_d;

    always_comb begin
        sw_clr = '0;
        if (wr_en && rsel == A_PEND) begin
            sw_clr = ~wdata;
        end
        // a set from an event takes precedence over any clear in the same cycle
        pend_d = (pend_q & ~sw_clr & ~ack_clr) | (evt & ena_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q  <= '0;
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_en && rsel == A_ENA) begin
                ena_q <= wdata;
            end
            if (wr_en && rsel == A_MASK) begin
                mask_q <= wdata;
            end
        end
    end

    always_comb begin
        unique case (rsel)
            A_ENA:   rd_val = ena_q;
            A_PEND:  rd_val = pend_q;
            A_MASK:  rd_val = mask_q;
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NCH   = 16,
    parameter int IDX_W = 4
) (
    input  logic [NCH-1:0]   req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        // ascending scan: the last hit, i.e. the highest channel, is kept
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm #(
    parameter int NCH    = 16,
    parameter int IDX_W  = 4,
    parameter int VEC_W  = 8,
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack_n,
    input  logic              cs_n,
    input  logic              iei_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [BASE_W-1:0] vbase,
    output logic              vec_oe,
    output logic [VEC_W-1:0]  vec_data,
    output logic [NCH-1:0]    ack_clr
);
    import vic_pkg::*;

    ack_state_t       state_q, state_d;
    logic             take;
    logic [VEC_W-1:0] vec_q;
    logic             ack_legal;

    assign ack_legal = !iack_n && cs_n;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_legal) begin
                    if (!iei_n && req_valid) begin
                        state_d = ST_RESP;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_PASS;
                    end
                end
            end
            ST_RESP: begin
                if (iack_n) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PASS: begin
                if (iack_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (take) begin
            vec_q <= {vbase, win_idx};
        end
    end

    always_comb begin
        vec_oe   = (state_q == ST_RESP);
        vec_data = vec_oe ? vec_q : '0;
        ack_clr  = '0;
        if (take) begin
            ack_clr[win_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/vector_irq_ctrl.sv
module vector_irq_ctrl #(
    parameter int NCH    = 16,
    parameter int DW     = 8,
    parameter int AW     = 5,
    parameter int VEC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we,
    input  logic [AW-1:0]    rsel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NCH-1:0]   evt_i,
    input  logic             iack_n,
    input  logic             iei_n,
    output logic             ieo_n,
    output logic             irq_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_data
);
    import vic_pkg::*;

    localparam int NBANK  = NCH / DW;
    localparam int IDX_W  = $clog2(NCH);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [AW-1:0] A_VBASE = AW'(KIND_VBASE * NBANK);

    logic              wr_en;
    logic              rd_en;
    logic [NCH-1:0]    ena_all;
    logic [NCH-1:0]    pend_all;
    logic [NCH-1:0]    mask_all;
    logic [NCH-1:0]    ack_clr;
    logic [DW-1:0]     bank_rd [NBANK];
    logic [BASE_W-1:0] vbase_q;
    logic              req_valid;
    logic [IDX_W-1:0]  win_idx;

    // chip select together with acknowledge is illegal and blocks register access
    assign wr_en = !cs_n && we && iack_n;
    assign rd_en = !cs_n && !we && iack_n;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        vic_bank #(
            .BANK_W (DW),
            .AW     (AW),
            .NBANK  (NBANK),
            .IDX    (b)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .rsel    (rsel),
            .wdata   (wdata),
            .evt     (evt_i[b*DW +: DW]),
            .ack_clr (ack_clr[b*DW +: DW]),
            .ena_q   (ena_all[b*DW +: DW]),
            .pend_q  (pend_all[b*DW +: DW]),
            .mask_q  (mask_all[b*DW +: DW]),
            .rd_val  (bank_rd[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbase_q <= '0;
        end else if (wr_en && rsel == A_VBASE) begin
            vbase_q <= wdata[DW-1 -: BASE_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int b = 0; b < NBANK; b++) begin
                rdata = rdata | bank_rd[b];
            end
            if (rsel == A_VBASE) begin
                rdata[DW-1 -: BASE_W] = vbase_q;
            end
        end
    end

    vic_prio #(
        .NCH   (NCH),
        .IDX_W (IDX_W)
    ) u_prio (
        .req   (pend_all & mask_all),
        .valid (req_valid),
        .idx   (win_idx)
    );

    vic_ack_fsm #(
        .NCH    (NCH),
        .IDX_W  (IDX_W),
        .VEC_W  (VEC_W),
        .BASE_W (BASE_W)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack_n    (iack_n),
        .cs_n      (cs_n),
        .iei_n     (iei_n),
        .req_valid (req_valid),
        .win_idx   (win_idx),
        .vbase     (vbase_q),
        .vec_oe    (vec_oe),
        .vec_data  (vec_data),
        .ack_clr   (ack_clr)
    );

    assign irq_n = !req_valid;
    assign ieo_n = iei_n || req_valid;

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NCH   = 16,
    parameter int IDX_W = 4,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             iack_n,
    input logic             iei_n,
    input logic             ieo_n,
    input logic             irq_n,
    input logic             vec_oe,
    input logic [VEC_W-1:0] vec_data,
    input logic [NCH-1:0]   evt_i,
    input logic [NCH-1:0]   ena_all,
    input logic [NCH-1:0]   pend_all,
    input logic [NCH-1:0]   mask_all
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pend_all == '0 && ena_all == '0 && mask_all == '0)); // R1

    AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pend_all & ~$past(pend_all) & ~$past(evt_i & ena_all)) == '0)); // R2

    AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !ieo_n |-> (!iei_n && irq_n)); // R9

    AST_RESP_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> $past(!iei_n && !iack_n && cs_n)); // R8

    AST_WINNER_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> (($past(pend_all & mask_all) >>
            ((IDX_W+1)'(vec_data[IDX_W-1:0]) + 1'b1)) == '0)); // R5

    AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_oe) && $past(evt_i) == '0) |-> !pend_all[vec_data[IDX_W-1:0]]); // R7

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !iack_n) |=> ($stable(ena_all) && $stable(mask_all))); // R10

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_data)); // R11

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && iack_n) |=> !vec_oe); // R11

endmodule

bind vector_irq_ctrl vic_checker #(
    .NCH   (NCH),
    .IDX_W (IDX_W),
    .VEC_W (VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .iack_n   (iack_n),
    .iei_n    (iei_n),
    .ieo_n    (ieo_n),
    .irq_n    (irq_n),
    .vec_oe   (vec_oe),
    .vec_data (vec_data),
    .evt_i    (evt_i),
    .ena_all  (ena_all),
    .pend_all (pend_all),
    .mask_all (mask_all)
);

// File: tb/vector_irq_ctrl_test.sv
module vector_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    localparam logic [15:0] TV_EVT [NV] = '{16'h0001, 16'h8001, 16'h8001, 16'h0F00,
                                           16'h00F0, 16'h0180, 16'h0180};
    localparam logic [15:0] TV_MSK [NV] = '{16'hFFFF, 16'hFFFF, 16'h7FFF, 16'hFFFF,
                                           16'h0000, 16'h0100, 16'h0080};
    localparam int          TV_IDX [NV] = '{0, 15, 0, 11, -1, 8, 7};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        we;
    logic [4:0]  rsel;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [15:0] evt;
    logic        iack_n;
    logic        iei_n;
    logic        ieo_n;
    logic        irq_n;
    logic        vec_oe;
    logic [7:0]  vec_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vector_irq_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we       (we),
        .rsel     (rsel),
        .wdata    (wdata),
        .rdata    (rdata),
        .evt_i    (evt),
        .iack_n   (iack_n),
        .iei_n    (iei_n),
        .ieo_n    (ieo_n),
        .irq_n    (irq_n),
        .vec_oe   (vec_oe),
        .vec_data (vec_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        cs_n = 1'b0; we = 1'b1; rsel = a; wdata = d;
        @(posedge clk); #1;
        cs_n = 1'b1; we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        cs_n = 1'b0; we = 1'b0; rsel = a;
        #1; d = rdata;
        @(posedge clk); #1;
        cs_n = 1'b1;
    endtask

    task automatic pulse(input logic [15:0] e);
        evt = e;
        @(posedge clk); #1;
        evt = '0;
    endtask

    task automatic ack_start();
        iack_n = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic ack_end();
        iack_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst_n = 1'b0; cs_n = 1'b1; we = 1'b0; rsel = '0; wdata = '0;
        evt = '0; iack_n = 1'b1; iei_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 vec_oe", vec_oe, 0);
        rd(5'h00, r); chk("R1 enable lo", r, 0);
        rd(5'h03, r); chk("R1 pending hi", r, 0);
        rd(5'h05, r); chk("R1 mask hi", r, 0);
        rd(5'h06, r); chk("R1 vbase", r, 0);
        chk("R9 ieo_n idle", ieo_n, 0);

        // R2 event on disabled channel is dropped
        pulse(16'h0004);
        rd(5'h02, r); chk("R2 disabled event", r, 8'h00);

        // R6 vector base keeps upper nibble
        wr(5'h06, 8'hA5);
        rd(5'h06, r); chk("R6 vbase readback", r, 8'hA0);
        wr(5'h00, 8'hFF); wr(5'h01, 8'hFF);

        // table walk: R3 request, R5 priority, R7 vector and clear
        for (int i = 0; i < NV; i++) begin
            wr(5'h02, 8'h00); wr(5'h03, 8'h00);
            wr(5'h04, TV_MSK[i][7:0]); wr(5'h05, TV_MSK[i][15:8]);
            pulse(TV_EVT[i]);
            chk("R3 table irq_n", irq_n, (TV_IDX[i] < 0) ? 1 : 0);
            if (TV_IDX[i] >= 0) begin
                ack_start();
                chk("R7 table vec_oe", vec_oe, 1);
                chk("R5 table vector", vec_data, {4'hA, 4'(TV_IDX[i])});
                ack_end();
                rd(5'(2 + TV_IDX[i] / 8), r);
                chk("R7 winner cleared", r[TV_IDX[i] % 8], 0);
            end
        end

        // R2 enabled set, repeat pulse keeps it set; R4 pending write semantics
        wr(5'h02, 8'h00); wr(5'h03, 8'h00);
        wr(5'h04, 8'hFF); wr(5'h05, 8'hFF);
        pulse(16'h0009);
        pulse(16'h0001);
        rd(5'h02, r); chk("R2 set and hold", r, 8'h09);
        wr(5'h02, 8'hFF);
        rd(5'h02, r); chk("R4 ones keep", r, 8'h09);
        wr(5'h02, 8'hFE);
        rd(5'h02, r); chk("R4 zero clears", r, 8'h08);

        // R9 chain with request
        chk("R9 ieo_n with request", ieo_n, 1);
        iei_n = 1'b1; #1;
        chk("R9 ieo_n upstream busy", ieo_n, 1);

        // R8 no grant: nothing driven, nothing cleared
        ack_start();
        chk("R8 vec_oe no grant", vec_oe, 0);
        chk("R8 vec_data no grant", vec_data, 0);
        ack_end();
        rd(5'h02, r); chk("R8 pending kept", r, 8'h08);
        iei_n = 1'b0;

        // R3 mask clear negates request
        wr(5'h04, 8'h00);
        chk("R3 mask clear", irq_n, 1);
        wr(5'h04, 8'hFF);
        chk("R3 mask restore", irq_n, 0);

        // R10 illegal overlap: write ignored, no acknowledge
        cs_n = 1'b0; we = 1'b1; rsel = 5'h04; wdata = 8'h00; iack_n = 1'b0;
        @(posedge clk); #1;
        chk("R10 no vector", vec_oe, 0);
        cs_n = 1'b1; we = 1'b0; iack_n = 1'b1;
        @(posedge clk); #1;
        rd(5'h04, r); chk("R10 mask unchanged", r, 8'hFF);

        // R7 request stays while others pend; R11 hold during new event
        pulse(16'h0020);
        ack_start();
        chk("R7 first vector", vec_data, 8'hA5);
        chk("R7 irq held", irq_n, 0);
        pulse(16'h8000);
        chk("R11 vector held", vec_data, 8'hA5);
        ack_start();
        chk("R11 still driving", vec_oe, 1);
        ack_end();
        chk("R11 released", vec_oe, 0);
        ack_start();
        chk("R5 new highest", vec_data, 8'hAF);
        ack_end();
        ack_start();
        chk("R7 last vector", vec_data, 8'hA3);
        ack_end();
        chk("R7 irq negated", irq_n, 1);
        chk("R9 ieo_n after drain", ieo_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule